// File: doc/BRIEF.md
# Triangular Spread-Spectrum Profile Generator

This block produces the digital modulation profile for a fractional feedback divider. Each clock is one output pulse. The block counts these pulses over a programmable spread period. In the first half of the period it raises a modulation offset by a fixed step on every pulse. In the second half it lowers the offset by the same step. The offset is added to a nominal divider ratio, and the result is driven out every cycle.

The period is set in pulses, so it can equal the number of pixels on one display line. The modulation then repeats at exactly the line rate, and every line sees the same frequency profile. An active-low enable keeps the output at the nominal ratio while spreading is off. The period length and the step size are taken only at period boundaries. The nominal ratio is used as soon as it arrives.

Top module: `ssg_profile_gen`

## Requirements
- R1: While reset is asserted, `div_out` equals `mod_in * 2^FRAC_W`, which means the offset is zero.
- R2: While `spread_off` is 1, the offset and the phase are held at zero, and `div_out` follows `mod_in * 2^FRAC_W` on the cycle after each edge. The period length and step are reloaded from the inputs on every such cycle.
- R3: When spreading is on, each clock in the first half of the period (phase below P/2, where P is the latched period) adds the latched step to the offset.
- R4: Each clock in the second half of the period (phase from P/2 to P-1) subtracts the latched step from the offset.
- R5: A period lasts exactly P clocks. After its last clock the offset is exactly zero again, and the phase restarts at 0.
- R6: The step is `nss_in - floor(nc_in/2)` when `nss_in` is larger than `floor(nc_in/2)`, and 0 otherwise. The peak offset is therefore (P/2) times the step.
- R7: An odd `nc_in` is rounded down to the even value below it.
- R8: A new `nc_in` or `nss_in` that arrives in the middle of a period has no effect until that period has finished.
- R9: A latched period below 2 produces no modulation. The offset stays zero, and the inputs are reloaded on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-pulse clock; one modulation step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_off | input | 1 | Active-low spread enable: 0 modulates, 1 holds the nominal ratio |
| nc_in | input | NC_W (11) | Pulses in one spread period |
| mod_in | input | MOD_W (13) | Nominal integer divider ratio |
| nss_in | input | NSS_W (13) | Spread amplitude parameter |
| div_out | output | MOD_W+FRAC_W+1 (24) | Divider value: `mod_in * 2^FRAC_W` plus the offset |

## Verification
The main risks are a phase counter that slips by one pulse and a step that is applied with the wrong sign. Either fault leaves a nonzero offset at the end of a period. That residue appears in `div_out` within one period and then grows with every further period. A step latched at the wrong moment shows up differently: the peak value or the slope changes in the very next cycle after a mid-period parameter change. The bench runs a cycle-accurate reference model alongside the block, so any difference is reported on the clock where it first appears.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  // Period length with the lowest bit cleared (odd values round down).
  function automatic int unsigned ssg_even(input int unsigned n);
    return n & ~32'd1;
  endfunction

  // Per-clock step: amplitude above half the period, or zero when it is not above.
  function automatic int unsigned ssg_step(input int unsigned nss, input int unsigned n);
    int unsigned half;
    half = n >> 1;
    return (nss > half) ? (nss - half) : 32'd0;
  endfunction

  // Largest offset reached at the top of the triangle.
  function automatic int unsigned ssg_peak(input int unsigned n, input int unsigned st);
    return (n >> 1) * st;
  endfunction

endpackage

// File: rtl/ssg_phase.sv
module ssg_phase
  import ssg_pkg::*;
#(
  parameter int NC_W  = 11,
  parameter int NSS_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spread_off,
  input  logic [NC_W-1:0]  nc_in,
  input  logic [NSS_W-1:0] nss_in,
  output logic             step_en,
  output logic             up_dir,
  output logic             wrap,
  output logic [NSS_W-1:0] step_q,
  output logic [NC_W-1:0]  nc_q
);

  logic [NC_W-1:0] ph_q;
  logic            active;
  logic            reload;

  assign active  = !spread_off && (nc_q > NC_W'(1));
  assign step_en = active;
  assign up_dir  = ph_q < (nc_q >> 1);
  assign wrap    = active && (ph_q == nc_q - NC_W'(1));
  assign reload  = !active || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      nc_q   <= '0;
      step_q <= '0;
    end else begin
      if (reload) begin
        nc_q   <= NC_W'(ssg_even(32'(nc_in)));
        step_q <= NSS_W'(ssg_step(32'(nss_in), 32'(nc_in)));
      end
      if (reload) ph_q <= '0;
      else        ph_q <= ph_q + NC_W'(1);
    end
  end

  // R5
  phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ph_q < nc_q));

  // R2
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_off |=> (ph_q == '0));

  // R7
  period_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (nc_q[0] == 1'b0));

endmodule

// File: rtl/ssg_ramp.sv
module ssg_ramp
  import ssg_pkg::*;
#(
  parameter int NC_W  = 11,
  parameter int NSS_W = 13,
  parameter int ACC_W = NC_W - 1 + NSS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spread_off,
  input  logic             step_en,
  input  logic             up_dir,
  input  logic             wrap,
  input  logic [NSS_W-1:0] step_q,
  input  logic [NC_W-1:0]  nc_q,
  output logic [ACC_W-1:0] acc_q
);

  logic [ACC_W-1:0] step_ext;
  assign step_ext = ACC_W'(step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (!step_en) acc_q <= '0;
    else if (up_dir)   acc_q <= acc_q + step_ext;
    else               acc_q <= acc_q - step_ext;
  end

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (acc_q == '0));

  // R6
  acc_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> (acc_q <= ACC_W'(ssg_peak(32'(nc_q), 32'(step_q)))));

  // R2
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_off |=> (acc_q == '0));

endmodule

// File: rtl/ssg_profile_gen.sv
module ssg_profile_gen #(
  parameter int NC_W   = 11,
  parameter int MOD_W  = 13,
  parameter int NSS_W  = 13,
  parameter int FRAC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spread_off,
  input  logic [NC_W-1:0]         nc_in,
  input  logic [MOD_W-1:0]        mod_in,
  input  logic [NSS_W-1:0]        nss_in,
  output logic [MOD_W+FRAC_W:0]   div_out
);

  localparam int ACC_W = NC_W - 1 + NSS_W;
  localparam int OUT_W = MOD_W + FRAC_W + 1;

  logic             step_en;
  logic             up_dir;
  logic             wrap;
  logic [NSS_W-1:0] step_q;
  logic [NC_W-1:0]  nc_q;
  logic [ACC_W-1:0] acc_q;
  logic [OUT_W-1:0] base;

  ssg_phase #(.NC_W(NC_W), .NSS_W(NSS_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .spread_off(spread_off),
    .nc_in(nc_in), .nss_in(nss_in),
    .step_en(step_en), .up_dir(up_dir), .wrap(wrap),
    .step_q(step_q), .nc_q(nc_q)
  );

  ssg_ramp #(.NC_W(NC_W), .NSS_W(NSS_W), .ACC_W(ACC_W)) ramp_i (
    .clk(clk), .rst_n(rst_n), .spread_off(spread_off),
    .step_en(step_en), .up_dir(up_dir), .wrap(wrap),
    .step_q(step_q), .nc_q(nc_q), .acc_q(acc_q)
  );

  assign base    = {1'b0, mod_in, FRAC_W'(0)};
  assign div_out = base + OUT_W'(acc_q);

  // R2
  out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spread_off |=> (div_out == {1'b0, mod_in, FRAC_W'(0)}));

endmodule

// File: tb/ssg_profile_gen_tb_top.sv
module ssg_profile_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAC_W = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spread_off;
  logic [10:0] nc_in;
  logic [12:0] mod_in;
  logic [12:0] nss_in;
  logic [23:0] div_out;

  int checks = 0;
  int fails  = 0;

  int unsigned m_ph, m_nca, m_st;
  longint      m_acc;
  string       m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssg_profile_gen dut_i (
    .clk(clk), .rst_n(rst_n), .spread_off(spread_off),
    .nc_in(nc_in), .mod_in(mod_in), .nss_in(nss_in), .div_out(div_out)
  );

  function automatic int unsigned exp_step(int unsigned nss, int unsigned nc);
    int unsigned h = nc / 2;
    if (nss <= h) return 0;
    return nss - h;
  endfunction

  function automatic longint nominal();
    return longint'(mod_in) * (longint'(1) << FRAC_W);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reload();
    m_nca = int'(nc_in) / 2 * 2;
    m_st  = exp_step(int'(nss_in), int'(nc_in));
  endtask

  task automatic tick();
    @(posedge clk);
    if (spread_off) begin
      m_tag = "R2"; m_ph = 0; m_acc = 0; model_reload();
    end else if (m_nca < 2) begin
      m_tag = "R9"; m_ph = 0; m_acc = 0; model_reload();
    end else begin
      if (m_ph < m_nca / 2) begin m_acc += m_st; m_tag = "R3"; end
      else                  begin m_acc -= m_st; m_tag = "R4"; end
      if (m_ph == m_nca - 1) begin m_ph = 0; model_reload(); m_tag = "R5"; end
      else m_ph++;
    end
    @(negedge clk);
    check(m_tag, longint'(div_out), nominal() + m_acc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(20240611));
    m_ph = 0; m_nca = 0; m_st = 0; m_acc = 0; m_tag = "R1";
    rst_n = 1'b0; spread_off = 1'b1; nc_in = 11'd8; nss_in = 13'd10; mod_in = 13'd100;
    repeat (3) @(negedge clk);
    check("R1", longint'(div_out), 100 * 1024);
    rst_n = 1'b1;
    repeat (3) tick();
    mod_in = 13'd200;
    tick();
    check("R2", longint'(div_out), 200 * 1024);

    // R3, R4, R6: P=8, step 6, peak 24
    spread_off = 1'b0;
    repeat (4) tick();
    check("R6", longint'(div_out), 200 * 1024 + 24);
    repeat (4) tick();
    check("R5", longint'(div_out), 200 * 1024);

    // R7: odd 9 behaves as 8, step 10-4=6
    spread_off = 1'b1; nc_in = 11'd9; tick();
    spread_off = 1'b0;
    repeat (4) tick();
    check("R7", longint'(div_out), 200 * 1024 + 24);
    repeat (4) tick();
    check("R7", longint'(div_out), 200 * 1024);

    // R8: mid-period change waits for the boundary
    nc_in = 11'd8;
    repeat (2) tick();
    nc_in = 11'd20; nss_in = 13'd15;
    tick();
    check("R8", longint'(div_out), 200 * 1024 + 18);
    repeat (5) tick();
    check("R8", longint'(div_out), 200 * 1024);
    repeat (10) tick();
    check("R8", longint'(div_out), 200 * 1024 + 50);
    repeat (10) tick();

    // R6 clamp: amplitude below half the period gives a flat output
    spread_off = 1'b1; nss_in = 13'd5; tick();
    spread_off = 1'b0;
    repeat (5) tick();
    check("R6", longint'(div_out), 200 * 1024);

    // R9: period 1 gives no modulation
    spread_off = 1'b1; nc_in = 11'd1; nss_in = 13'd40; tick();
    spread_off = 1'b0;
    repeat (5) tick();
    check("R9", longint'(div_out), 200 * 1024);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 49) == 0) begin
        int unsigned n = $urandom_range(0, 40);
        nc_in  = 11'(n);
        nss_in = 13'((n / 2) + $urandom_range(0, 60) - ($urandom_range(0, 3) == 0 ? n / 2 : 0));
        mod_in = 13'($urandom_range(0, 8191));
      end
      if ($urandom_range(0, 199) == 0) spread_off = ~spread_off;
      tick();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule